// File: doc/BRIEF.md
# I2C Channel Interrupt Aggregator

This block keeps the interrupt enable and interrupt status registers for a set of I2C bus channels and combines them into one controller-level summary word and a single interrupt line. The command engine of each channel sends one-cycle event pulses: acknowledge, not-acknowledge, receive done, arbitration loss, normal stop and abnormal stop. Each pulse raises that channel's interrupt. A raise ORs the pulses into the status register and then keeps only the enabled bits. The summary word holds one bit per channel. A channel's bit is set while that channel has status left, and the interrupt line is the OR of all summary bits.

Software uses a register port with a valid strobe, a write flag, a register select, a channel number and write data. It reads a register select combinationally. It clears status by writing ones. If software clears a pending receive-done while the channel still has a receive command armed, the block sends a one-cycle re-receive request back to the command engine. On the next edge it evaluates the interrupt again.

Top module: `i2c_irq_aggregator`

## Requirements
- R1: An event pulse on a channel sets its status to (old status OR events) AND enable at the next edge. The event encoding is bit0 ack, bit1 nak, bit2 receive done, bit3 arbitration loss, bit4 normal stop, bit5 abnormal stop. Writing the enable register alone never re-masks status.
- R2: When a raise leaves the channel status non-zero, summary bit [channel] is set at the same edge.
- R3: A status write (select 2) clears exactly the status bits written as one and leaves the others.
- R4: When a status write or a re-evaluation leaves the status at zero, summary bit [channel] drops at that edge.
- R5: An enable write (select 1) stores the 15-bit value, and it reads back unchanged.
- R6: The re-receive request for a channel is high for exactly one cycle after the edge of a status write. It is only raised when status bit2 was set, the written value has bit2 set, and the channel's receive-armed input is high. Otherwise it stays low.
- R7: One edge after a re-receive request is issued, the channel status is ANDed with the current enable, with R4 applying.
- R8: When an event pulse and a status clear hit the same bit in the same cycle, the bit stays set.
- R9: A channel reset clears that channel's enable and status and nothing else, including its summary bit. The controller reset clears everything, the summary word included.
- R10: The summary word (select 0) is read-only, and writes to it have no effect.
- R11: The interrupt output is high exactly when the summary word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| ch_rst_i | input | NUM_CH | Synchronous per-channel reset |
| evt_i | input | NUM_CH*6 | Event pulses, 6 bits per channel |
| rx_armed_i | input | NUM_CH | A receive or receive-last command is armed on the channel |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | Access is a write |
| reg_sel_i | input | 2 | 0 summary, 1 enable, 2 status, 3 none |
| reg_ch_i | input | 4 | Channel number |
| reg_wdata_i | input | 15 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for select and channel |
| irq_o | output | 1 | Combined interrupt |
| rerx_o | output | NUM_CH | One-cycle re-receive request per channel |

## Verification
Event pulses and register writes take effect at the edge that samples them. The read port is combinational, so the bench drives on the falling edge and reads the result at the next falling edge. The re-receive request is visible in the cycle right after the status-write edge. The re-evaluation it triggers shows in status one edge later, so the R7 checks read status once after the write and once more after one extra clock. Simultaneous event and clear are driven in the same falling-edge slot, so both meet the same rising edge.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int STS_W       = 15;
    localparam int EVT_W       = 6;
    localparam int RD_W        = 16;
    localparam int CHN_W       = 4;
    localparam int RX_DONE_BIT = 2;

    typedef enum logic [1:0] {
        SEL_SUMMARY = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [STS_W-1:0] en;
        logic [STS_W-1:0] sts;
        logic             pend;
        logic             gbit;
    } chan_state_t;
endpackage

// File: rtl/irqagg_chan.sv
module irqagg_chan
    import irqagg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_rst,
    input  logic [EVT_W-1:0] evt,
    input  logic             rx_armed,
    input  logic             en_we,
    input  logic             sts_we,
    input  logic [STS_W-1:0] wdata,
    output logic [STS_W-1:0] en_o,
    output logic [STS_W-1:0] sts_o,
    output logic             gbit_o,
    output logic             rerx_o
);
    chan_state_t st_d, st_q;

    logic [STS_W-1:0] clr_mask;
    logic [STS_W-1:0] after_clr;
    logic [STS_W-1:0] evt_ext;
    logic             raise;
    logic             retrig;

    always_comb begin
        st_d      = st_q;
        clr_mask  = sts_we ? wdata : '0;
        after_clr = st_q.sts & ~clr_mask;
        evt_ext   = {{(STS_W-EVT_W){1'b0}}, evt};
        raise     = (|evt) || st_q.pend;
        retrig    = sts_we && st_q.sts[RX_DONE_BIT] && wdata[RX_DONE_BIT] && rx_armed;

        // events are merged after the clear so a coincident event survives
        if (raise) begin
            st_d.sts = (after_clr | evt_ext) & st_q.en;
        end else begin
            st_d.sts = after_clr;
        end
        st_d.pend = retrig;

        if (en_we) begin
            st_d.en = wdata;
        end

        if (raise && (|st_d.sts)) begin
            st_d.gbit = 1'b1;
        end else if ((raise || sts_we) && (st_d.sts == '0)) begin
            st_d.gbit = 1'b0;
        end

        // channel reset leaves the controller-level summary bit alone
        if (ch_rst) begin
            st_d.en   = '0;
            st_d.sts  = '0;
            st_d.pend = 1'b0;
            st_d.gbit = st_q.gbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign sts_o  = st_q.sts;
    assign gbit_o = st_q.gbit;
    assign rerx_o = st_q.pend;
endmodule

// File: rtl/irqagg_regdec.sv
module irqagg_regdec
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [1:0]       reg_sel,
    input  logic [CHN_W-1:0] reg_ch,
    input  logic [STS_W-1:0] en_arr  [NUM_CH],
    input  logic [STS_W-1:0] sts_arr [NUM_CH],
    input  logic [NUM_CH-1:0] gbits,
    output logic [NUM_CH-1:0] en_we,
    output logic [NUM_CH-1:0] sts_we,
    output logic [RD_W-1:0]   rdata
);
    logic            ch_ok;
    logic            wr;
    logic [CH_W-1:0] idx;
    reg_sel_e        sel;

    assign ch_ok = ({1'b0, reg_ch} < (CHN_W+1)'(NUM_CH));
    assign wr    = reg_valid && reg_write;
    assign idx   = reg_ch[CH_W-1:0];
    assign sel   = reg_sel_e'(reg_sel);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
        assign en_we[i]  = wr && (sel == SEL_ENABLE) && (reg_ch == CHN_W'(i));
        assign sts_we[i] = wr && (sel == SEL_STATUS) && (reg_ch == CHN_W'(i));
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_SUMMARY: rdata = RD_W'(gbits);
            SEL_ENABLE:  if (ch_ok) rdata = RD_W'(en_arr[idx]);
            SEL_STATUS:  if (ch_ok) rdata = RD_W'(sts_arr[idx]);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_aggregator.sv
module i2c_irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_rst_i,
    input  logic [NUM_CH*EVT_W-1:0] evt_i,
    input  logic [NUM_CH-1:0]       rx_armed_i,
    input  logic                    reg_valid_i,
    input  logic                    reg_write_i,
    input  logic [1:0]              reg_sel_i,
    input  logic [CHN_W-1:0]        reg_ch_i,
    input  logic [STS_W-1:0]        reg_wdata_i,
    output logic [RD_W-1:0]         reg_rdata_o,
    output logic                    irq_o,
    output logic [NUM_CH-1:0]       rerx_o
);
    logic [STS_W-1:0]        en_arr  [NUM_CH];
    logic [STS_W-1:0]        sts_arr [NUM_CH];
    logic [NUM_CH*STS_W-1:0] sts_flat_w;
    logic [NUM_CH-1:0]       gbit_w;
    logic [NUM_CH-1:0]       en_we_w;
    logic [NUM_CH-1:0]       sts_we_w;

    irqagg_regdec #(.NUM_CH(NUM_CH)) u_dec (
        .reg_valid (reg_valid_i),
        .reg_write (reg_write_i),
        .reg_sel   (reg_sel_i),
        .reg_ch    (reg_ch_i),
        .en_arr    (en_arr),
        .sts_arr   (sts_arr),
        .gbits     (gbit_w),
        .en_we     (en_we_w),
        .sts_we    (sts_we_w),
        .rdata     (reg_rdata_o)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        irqagg_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ch_rst   (ch_rst_i[i]),
            .evt      (evt_i[i*EVT_W +: EVT_W]),
            .rx_armed (rx_armed_i[i]),
            .en_we    (en_we_w[i]),
            .sts_we   (sts_we_w[i]),
            .wdata    (reg_wdata_i),
            .en_o     (en_arr[i]),
            .sts_o    (sts_arr[i]),
            .gbit_o   (gbit_w[i]),
            .rerx_o   (rerx_o[i])
        );
        assign sts_flat_w[i*STS_W +: STS_W] = sts_arr[i];
    end

    assign irq_o = |gbit_w;
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    irq,
    input logic [NUM_CH-1:0]       rerx,
    input logic [NUM_CH-1:0]       gbits,
    input logic [NUM_CH*STS_W-1:0] sts_flat,
    input logic [NUM_CH*EVT_W-1:0] evt,
    input logic                    reg_valid,
    input logic                    reg_write,
    input logic [1:0]              reg_sel,
    input logic [STS_W-1:0]        reg_wdata
);
    logic sts_wr;
    assign sts_wr = reg_valid && reg_write && (reg_sel == 2'(SEL_STATUS));

    assert_rerx_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rerx) |-> $past(sts_wr && reg_wdata[RX_DONE_BIT]));

    assert_rerx_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rerx));

    assert_irq_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|evt));

    assert_irq_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(sts_wr || (|rerx)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_status_sets_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_flat[i*STS_W +: STS_W] != '0) |-> gbits[i]);
    end
endmodule

bind i2c_irq_aggregator irqagg_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq_o),
    .rerx      (rerx_o),
    .gbits     (gbit_w),
    .sts_flat  (sts_flat_w),
    .evt       (evt_i),
    .reg_valid (reg_valid_i),
    .reg_write (reg_write_i),
    .reg_sel   (reg_sel_i),
    .reg_wdata (reg_wdata_i)
);

// File: tb/i2c_irq_aggregator_test.sv
module i2c_irq_aggregator_test;
    localparam int PERIOD   = 10;
    localparam int NCH      = 4;
    localparam int WATCHDOG = 20000;

    localparam logic [1:0] K_EV = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_IRQ = 2'd3;
    localparam logic [1:0] S_G = 2'd0, S_E = 2'd1, S_S = 2'd2;

    typedef struct packed {
        logic [1:0]  k;
        logic [3:0]  ch;
        logic [1:0]  a;
        logic [15:0] d;
        logic [15:0] e;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0000, 4'd9},  // R9 reset value
        '{K_RD,  4'd0, S_E, 16'h0000, 16'h0000, 4'd9},  // R9
        '{K_WR,  4'd0, S_E, 16'h7FFF, 16'h0000, 4'd5},  // R5
        '{K_RD,  4'd0, S_E, 16'h0000, 16'h7FFF, 4'd5},  // R5
        '{K_EV,  4'd0, S_S, 16'h0001, 16'h0000, 4'd1},  // R1 ack
        '{K_RD,  4'd0, S_S, 16'h0000, 16'h0001, 4'd1},  // R1
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0001, 4'd2},  // R2
        '{K_IRQ, 4'd0, S_G, 16'h0000, 16'h0001, 4'd11}, // R11
        '{K_WR,  4'd1, S_E, 16'h0004, 16'h0000, 4'd5},  // R5
        '{K_EV,  4'd1, S_S, 16'h0003, 16'h0000, 4'd1},  // R1 masked out
        '{K_RD,  4'd1, S_S, 16'h0000, 16'h0000, 4'd1},  // R1
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0001, 4'd2},  // R2
        '{K_EV,  4'd1, S_S, 16'h0004, 16'h0000, 4'd1},  // R1 rx done
        '{K_RD,  4'd1, S_S, 16'h0000, 16'h0004, 4'd1},  // R1
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0003, 4'd2},  // R2
        '{K_WR,  4'd0, S_S, 16'h0002, 16'h0000, 4'd3},  // R3 clear of unset bit
        '{K_RD,  4'd0, S_S, 16'h0000, 16'h0001, 4'd3},  // R3
        '{K_WR,  4'd0, S_S, 16'h0001, 16'h0000, 4'd3},  // R3
        '{K_RD,  4'd0, S_S, 16'h0000, 16'h0000, 4'd3},  // R3
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0002, 4'd4},  // R4
        '{K_IRQ, 4'd0, S_G, 16'h0000, 16'h0001, 4'd11}, // R11
        '{K_WR,  4'd1, S_S, 16'h0004, 16'h0000, 4'd4},  // R4
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0000, 4'd4},  // R4
        '{K_IRQ, 4'd0, S_G, 16'h0000, 16'h0000, 4'd11}, // R11
        '{K_WR,  4'd0, S_G, 16'h7FFF, 16'h0000, 4'd10}, // R10
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0000, 4'd10}, // R10
        '{K_WR,  4'd2, S_E, 16'h003F, 16'h0000, 4'd1},  // R1
        '{K_EV,  4'd2, S_S, 16'h0011, 16'h0000, 4'd1},  // R1
        '{K_RD,  4'd2, S_S, 16'h0000, 16'h0011, 4'd1},  // R1
        '{K_WR,  4'd2, S_E, 16'h0001, 16'h0000, 4'd1},  // R1
        '{K_RD,  4'd2, S_S, 16'h0000, 16'h0011, 4'd1},  // R1 enable write alone
        '{K_EV,  4'd2, S_S, 16'h0002, 16'h0000, 4'd1},  // R1 raise re-masks
        '{K_RD,  4'd2, S_S, 16'h0000, 16'h0001, 4'd1},  // R1
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0004, 4'd2},  // R2
        '{K_WR,  4'd2, S_S, 16'h7FFF, 16'h0000, 4'd4},  // R4
        '{K_RD,  4'd0, S_G, 16'h0000, 16'h0000, 4'd4}   // R4
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ch_rst = '0;
    logic [NCH*6-1:0]  evt = '0;
    logic [NCH-1:0]    rx_armed = '0;
    logic              reg_valid = 1'b0;
    logic              reg_write = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [3:0]        reg_ch = 4'd0;
    logic [14:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              irq;
    logic [NCH-1:0]    rerx;

    int n_chk  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    i2c_irq_aggregator #(.NUM_CH(NCH)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_rst_i    (ch_rst),
        .evt_i       (evt),
        .rx_armed_i  (rx_armed),
        .reg_valid_i (reg_valid),
        .reg_write_i (reg_write),
        .reg_sel_i   (reg_sel),
        .reg_ch_i    (reg_ch),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq),
        .rerx_o      (rerx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [1:0] sel, input logic [14:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_ch = 4'(ch); reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic ev(input int ch, input logic [5:0] bits);
        @(negedge clk);
        evt[ch*6 +: 6] = bits;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd(input int ch, input logic [1:0] sel, output logic [15:0] v);
        reg_ch = 4'(ch); reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9 irq after reset", 32'(irq), 32'd0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].k)
                K_EV:  ev(int'(VECS[i].ch), VECS[i].d[5:0]);
                K_WR:  wr(int'(VECS[i].ch), VECS[i].a, VECS[i].d[14:0]);
                K_RD: begin
                    rd(int'(VECS[i].ch), VECS[i].a, v);
                    chk($sformatf("R%0d vector %0d", VECS[i].r, i), 32'(v), 32'(VECS[i].e));
                end
                default: chk($sformatf("R%0d vector %0d irq", VECS[i].r, i), 32'(irq), 32'(VECS[i].e[0]));
            endcase
        end

        // R8: event and clear on the same bit in one cycle
        @(negedge clk);
        evt[5:0] = 6'h01;
        reg_valid = 1'b1; reg_write = 1'b1; reg_ch = 4'd0; reg_sel = S_S; reg_wdata = 15'h0001;
        @(negedge clk);
        evt = '0; reg_valid = 1'b0; reg_write = 1'b0;
        rd(0, S_S, v); chk("R8 event wins over clear", 32'(v), 32'h1);
        wr(0, S_S, 15'h0001);

        // R6 and R7: re-receive request
        wr(3, S_E, 15'h7FFF);
        ev(3, 6'h05);
        rx_armed[3] = 1'b1;
        wr(3, S_S, 15'h0004);
        chk("R6 request issued", 32'(rerx), 32'h8);
        rd(3, S_S, v); chk("R6 rx done cleared", 32'(v), 32'h1);
        @(negedge clk);
        chk("R6 request lasts one cycle", 32'(rerx), 32'h0);
        rd(3, S_S, v); chk("R7 re-evaluation keeps enabled bits", 32'(v), 32'h1);
        ev(3, 6'h04);
        wr(3, S_E, 15'h0004);
        wr(3, S_S, 15'h0004);
        rd(3, S_S, v); chk("R7 status after clear", 32'(v), 32'h1);
        rd(0, S_G, v); chk("R7 summary before re-evaluation", 32'(v), 32'h8);
        @(negedge clk);
        rd(3, S_S, v); chk("R7 status after re-evaluation", 32'(v), 32'h0);
        rd(0, S_G, v); chk("R7 summary drops", 32'(v), 32'h0);
        chk("R11 irq low after re-evaluation", 32'(irq), 32'd0);

        // R6 negative cases
        rx_armed[3] = 1'b0;
        ev(3, 6'h04);
        wr(3, S_S, 15'h0004);
        chk("R6 no request when not armed", 32'(rerx), 32'h0);
        rx_armed[3] = 1'b1;
        wr(3, S_S, 15'h0004);
        chk("R6 no request when rx done not set", 32'(rerx), 32'h0);
        ev(3, 6'h04);
        wr(3, S_S, 15'h0001);
        chk("R6 no request when bit2 not written", 32'(rerx), 32'h0);
        rd(3, S_S, v); chk("R3 unwritten bit kept", 32'(v), 32'h4);
        rx_armed[3] = 1'b0;
        wr(3, S_S, 15'h0004);

        // R9: channel reset then controller reset
        ev(0, 6'h01);
        @(negedge clk);
        ch_rst[0] = 1'b1;
        @(negedge clk);
        ch_rst[0] = 1'b0;
        rd(0, S_E, v); chk("R9 channel reset clears enable", 32'(v), 32'h0);
        rd(0, S_S, v); chk("R9 channel reset clears status", 32'(v), 32'h0);
        rd(1, S_E, v); chk("R9 other channel untouched", 32'(v), 32'h4);
        rd(0, S_G, v); chk("R9 summary kept on channel reset", 32'(v), 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rd(0, S_G, v); chk("R9 controller reset clears summary", 32'(v), 32'h0);
        rd(1, S_E, v); chk("R9 controller reset clears enable", 32'(v), 32'h0);
        chk("R11 irq low in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule